// File: doc/BRIEF.md
# USB IN Token Responder

This block chooses the answer a USB device controller gives when the host sends an IN token to a bulk, interrupt or control endpoint. Each token arrives as a one-cycle strobe with an endpoint number. The block compares it with that endpoint's transmit FIFO and with a per-endpoint halt bit. If the FIFO holds a word, the block pops it and hands it to the serial engine as a DATA response. If the FIFO is empty, the block answers NAK and flags the endpoint for software. A halted endpoint always answers STALL. Isochronous traffic never reaches this block.

Software finds the cause of an interrupt through a small register window. A flag register has one bit per endpoint and shows which endpoint asked for service. Each endpoint also has a cause register that records that an IN token found its FIFO empty. Both are cleared by writing 1. Software then refills the FIFO, and the host's next retry of the same endpoint is served with the new word. Packet framing, CRC and the refill path are outside this block.

Top module: `usb_in_responder`

## Requirements
- R1: After reset, `resp_valid` is 0, `resp_code` is 2'b00 and `irq` is 0. The flag, halt and cause registers read 0, and the mask register reads all ones.
- R2: Take an IN token for an in-range endpoint that is not halted and whose FIFO is not empty. In the token's cycle, `fifo_rd` pulses for that endpoint only. One cycle later, `resp_valid` is 1, `resp_code` is 2'b01 (DATA) and `resp_data` holds the word the FIFO presented.
- R3: Take an IN token for an in-range endpoint that is not halted and whose FIFO is empty. No pop occurs. One cycle later, `resp_valid` is 1 and `resp_code` is 2'b10 (NAK).
- R4: That NAK also sets the endpoint's bit in the flag register (address 0, bit n for endpoint n). It also sets bit 0 of the endpoint's cause register (address 4+n). Both are visible in the cycle after the token.
- R5: When an endpoint's halt bit (address 2, bit n) is 1, a token for it gets `resp_code` 2'b11 (STALL) one cycle later, whatever the FIFO holds. It causes no pop and sets no flag or cause bit.
- R6: `irq` is 1 exactly when some flag bit is set whose bit in the mask register (address 1, 1 = enabled) is also set. It follows register changes in the cycle after they are written.
- R7: Writing 1 to a flag bit, or to bit 0 of a cause register, clears that bit. Writing 0 leaves it unchanged. A NAK in the same cycle as a clear of the same bit leaves the bit set.
- R8: A token whose endpoint number is `NUM_EP` or above gives no response, no pop and no change to any flag.
- R9: A retry after software has refilled an endpoint's FIFO receives DATA carrying the refilled word.
- R10: `reg_rdata` follows `reg_addr` combinationally. Addresses 0, 1 and 2 return the flag, mask and halt registers. Address 4+n returns endpoint n's cause bit in bit 0. Any other address returns 0. Address 1 and address 2 are written with the full value.
- R11: Tokens on consecutive cycles are each answered one cycle later, in order, and successive pops of one endpoint return that FIFO's words in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | IN token strobe |
| tok_ep | input | EP_W | Endpoint number of the token |
| fifo_empty | input | NUM_EP | Per-endpoint transmit FIFO empty flags |
| fifo_rdata | input | NUM_EP*DATA_W | Per-endpoint FIFO head words, endpoint n at bits n*DATA_W upward |
| fifo_rd | output | NUM_EP | Per-endpoint pop strobe, same cycle as the token |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 01 DATA, 10 NAK, 11 STALL, 00 none |
| resp_data | output | DATA_W | Word for a DATA response |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_EP | Register write data |
| reg_rdata | output | NUM_EP | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Pop strobes are combinational, so the bench samples `fifo_rd` one time step after it drives the token, while the token's cycle is still in progress. The response and the flag and cause updates come from one register stage, so the bench compares them, and `irq`, on the falling edge after the next rising edge. Register reads are combinational, so they are sampled a step after the address changes. A behavioural model holds the FIFO contents and the register state, and the bench compares against it on every clock.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_DATA  = 2'b01,
        RSP_NAK   = 2'b10,
        RSP_STALL = 2'b11
    } rsp_code_e;

    localparam int unsigned ADDR_FLAGS      = 0;
    localparam int unsigned ADDR_MASK       = 1;
    localparam int unsigned ADDR_HALT       = 2;
    localparam int unsigned ADDR_CAUSE_BASE = 4;

endpackage

// File: rtl/usb_in_decide.sv
module usb_in_decide
    import usb_in_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned EP_W   = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     tok_valid,
    input  logic [EP_W-1:0]          tok_ep,
    input  logic [NUM_EP-1:0]        fifo_empty,
    input  logic [NUM_EP*DATA_W-1:0] fifo_rdata,
    input  logic [NUM_EP-1:0]        halt,
    output logic [NUM_EP-1:0]        pop,
    output logic [NUM_EP-1:0]        nak_hit,
    output rsp_code_e                code,
    output logic [DATA_W-1:0]        data
);

    logic [NUM_EP-1:0] sel;
    logic [NUM_EP-1:0] stall_hit;

    // One decision lane per endpoint; out-of-range numbers select no lane.
    for (genvar e = 0; e < NUM_EP; e++) begin : g_lane
        assign sel[e]       = tok_valid && (tok_ep == EP_W'(e));
        assign stall_hit[e] = sel[e] && halt[e];
        assign pop[e]       = sel[e] && !halt[e] && !fifo_empty[e];
        assign nak_hit[e]   = sel[e] && !halt[e] && fifo_empty[e];
    end

    always_comb begin
        if (|stall_hit)    code = RSP_STALL;
        else if (|nak_hit) code = RSP_NAK;
        else if (|pop)     code = RSP_DATA;
        else               code = RSP_NONE;
    end

    // AND-OR mux over the one-hot pop vector.
    always_comb begin
        data = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (pop[e]) data = data | fifo_rdata[e*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/usb_in_csr.sv
module usb_in_csr
    import usb_in_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_EP-1:0] reg_wdata,
    input  logic [NUM_EP-1:0] nak_hit,
    output logic [NUM_EP-1:0] halt,
    output logic [NUM_EP-1:0] flags,
    output logic [NUM_EP-1:0] reg_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_EP-1:0] flags;
        logic [NUM_EP-1:0] mask;
        logic [NUM_EP-1:0] halt;
        logic [NUM_EP-1:0] cause;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_FLAGS)) csr_d.flags = csr_q.flags & ~reg_wdata;
            if (reg_addr == ADDR_W'(ADDR_MASK))  csr_d.mask  = reg_wdata;
            if (reg_addr == ADDR_W'(ADDR_HALT))  csr_d.halt  = reg_wdata;
            for (int e = 0; e < NUM_EP; e++) begin
                if (reg_addr == ADDR_W'(ADDR_CAUSE_BASE + e) && reg_wdata[0])
                    csr_d.cause[e] = 1'b0;
            end
        end
        // New events are applied after clears, so they win a same-cycle race.
        csr_d.flags = csr_d.flags | nak_hit;
        csr_d.cause = csr_d.cause | nak_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q.flags <= '0;
            csr_q.mask  <= '1;
            csr_q.halt  <= '0;
            csr_q.cause <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_FLAGS)) reg_rdata = csr_q.flags;
        if (reg_addr == ADDR_W'(ADDR_MASK))  reg_rdata = csr_q.mask;
        if (reg_addr == ADDR_W'(ADDR_HALT))  reg_rdata = csr_q.halt;
        for (int e = 0; e < NUM_EP; e++) begin
            if (reg_addr == ADDR_W'(ADDR_CAUSE_BASE + e)) reg_rdata[0] = csr_q.cause[e];
        end
    end

    assign halt  = csr_q.halt;
    assign flags = csr_q.flags;
    assign irq   = |(csr_q.flags & csr_q.mask);

endmodule

// File: rtl/usb_in_responder.sv
module usb_in_responder
    import usb_in_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned EP_W   = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tok_valid,
    input  logic [EP_W-1:0]          tok_ep,
    input  logic [NUM_EP-1:0]        fifo_empty,
    input  logic [NUM_EP*DATA_W-1:0] fifo_rdata,
    output logic [NUM_EP-1:0]        fifo_rd,
    output logic                     resp_valid,
    output logic [1:0]               resp_code,
    output logic [DATA_W-1:0]        resp_data,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [NUM_EP-1:0]        reg_wdata,
    output logic [NUM_EP-1:0]        reg_rdata,
    output logic                     irq
);

    typedef struct packed {
        logic              vld;
        rsp_code_e         code;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic [NUM_EP-1:0] halt;
    logic [NUM_EP-1:0] flags;
    logic [NUM_EP-1:0] nak_hit;
    rsp_code_e         code;
    logic [DATA_W-1:0] word;
    rsp_t              rsp_d, rsp_q;

    usb_in_decide #(.NUM_EP(NUM_EP), .EP_W(EP_W), .DATA_W(DATA_W)) u_decide (
        .tok_valid  (tok_valid),
        .tok_ep     (tok_ep),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .halt       (halt),
        .pop        (fifo_rd),
        .nak_hit    (nak_hit),
        .code       (code),
        .data       (word)
    );

    usb_in_csr #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .nak_hit   (nak_hit),
        .halt      (halt),
        .flags     (flags),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always_comb begin
        rsp_d.vld  = (code != RSP_NONE);
        rsp_d.code = code;
        rsp_d.data = (code == RSP_DATA) ? word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q.vld  <= 1'b0;
            rsp_q.code <= RSP_NONE;
            rsp_q.data <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid = rsp_q.vld;
    assign resp_code  = rsp_q.code;
    assign resp_data  = rsp_q.data;

endmodule

// File: rtl/usb_in_responder_chk.sv
module usb_in_responder_chk #(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned EP_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [EP_W-1:0]   tok_ep,
    input logic [NUM_EP-1:0] fifo_empty,
    input logic [NUM_EP-1:0] fifo_rd,
    input logic              resp_valid,
    input logic [1:0]        resp_code,
    input logic [NUM_EP-1:0] halt,
    input logic [NUM_EP-1:0] flags
);

    logic [NUM_EP-1:0] tok_sel;
    always_comb begin
        for (int e = 0; e < NUM_EP; e++) tok_sel[e] = tok_valid && (tok_ep == EP_W'(e));
    end

    a_r2_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_rd));

    a_r2_pop_gives_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd != '0) |=> (resp_valid && resp_code == 2'b01));

    a_r3_empty_naks: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tok_sel & fifo_empty & ~halt)) |=> (resp_valid && resp_code == 2'b10));

    a_r4_nak_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tok_sel & fifo_empty & ~halt)) |=> ((flags & $past(tok_sel)) != '0));

    a_r5_stall_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tok_sel & halt)) |-> (fifo_rd == '0));

    a_r5_stall_code: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tok_sel & halt)) |=> (resp_code == 2'b11));

    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_sel == '0) |=> !resp_valid);

    a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

endmodule

bind usb_in_responder usb_in_responder_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_ep     (tok_ep),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .halt       (halt),
    .flags      (flags)
);

// File: tb/usb_in_responder_test.sv
module usb_in_responder_test;

    localparam int NUM_EP     = 4;
    localparam int EP_W       = 4;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     tok_valid = 1'b0;
    logic [EP_W-1:0]          tok_ep = '0;
    logic [NUM_EP-1:0]        fifo_empty = '1;
    logic [NUM_EP*DATA_W-1:0] fifo_rdata = '0;
    logic [NUM_EP-1:0]        fifo_rd;
    logic                     resp_valid;
    logic [1:0]               resp_code;
    logic [DATA_W-1:0]        resp_data;
    logic                     reg_wr = 1'b0;
    logic [ADDR_W-1:0]        reg_addr = '0;
    logic [NUM_EP-1:0]        reg_wdata = '0;
    logic [NUM_EP-1:0]        reg_rdata;
    logic                     irq;

    usb_in_responder #(.NUM_EP(NUM_EP), .EP_W(EP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_data(resp_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Behavioural model state
    logic [DATA_W-1:0] fdat [NUM_EP][DEPTH];
    int                fhead [NUM_EP];
    int                fcnt  [NUM_EP];
    logic [NUM_EP-1:0] m_flags = '0, m_mask = '1, m_halt = '0, m_cause = '0;

    task automatic chk(int act, int exp, string tag, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive_fifo();
        for (int e = 0; e < NUM_EP; e++) begin
            fifo_empty[e] = (fcnt[e] == 0);
            fifo_rdata[e*DATA_W +: DATA_W] = fdat[e][fhead[e]];
        end
    endtask

    task automatic push(int ep, int val);
        fdat[ep][(fhead[ep] + fcnt[ep]) % DEPTH] = val[DATA_W-1:0];
        fcnt[ep]++;
        drive_fifo();
    endtask

    function automatic int model_reg(int addr);
        if (addr == 0) return int'(m_flags);
        if (addr == 1) return int'(m_mask);
        if (addr == 2) return int'(m_halt);
        if (addr >= 4 && addr < 4 + NUM_EP) return int'(m_cause[addr-4]);
        return 0;
    endfunction

    task automatic rd(int addr, string tag);
        reg_addr = addr[ADDR_W-1:0];
        #1;
        chk(int'(reg_rdata), model_reg(addr), tag, $sformatf("reg_rdata@%0d", addr));
    endtask

    // One clock: drive at the falling edge, check pops, step the model, check results.
    task automatic cycle(bit tv, int tep, bit wr, int addr, int wdata, string tag);
        logic [NUM_EP-1:0] exp_pop = '0;
        int e_code = 0;
        int e_data = 0;
        bit nak = 0;
        tok_valid = tv;
        tok_ep    = tep[EP_W-1:0];
        reg_wr    = wr;
        reg_addr  = addr[ADDR_W-1:0];
        reg_wdata = wdata[NUM_EP-1:0];
        drive_fifo();
        #1;
        if (tv && tep < NUM_EP) begin
            if (m_halt[tep]) e_code = 3;
            else if (fcnt[tep] == 0) begin
                e_code = 2;
                nak = 1;
            end else begin
                e_code = 1;
                e_data = int'(fdat[tep][fhead[tep]]);
                exp_pop[tep] = 1'b1;
                fhead[tep] = (fhead[tep] + 1) % DEPTH;
                fcnt[tep]--;
            end
        end
        chk(int'(fifo_rd), int'(exp_pop), tag, "fifo_rd");
        if (wr) begin
            if (addr == 0) m_flags = m_flags & ~wdata[NUM_EP-1:0];
            if (addr == 1) m_mask = wdata[NUM_EP-1:0];
            if (addr == 2) m_halt = wdata[NUM_EP-1:0];
            if (addr >= 4 && addr < 4 + NUM_EP && wdata[0]) m_cause[addr-4] = 1'b0;
        end
        if (nak) begin
            m_flags[tep] = 1'b1;
            m_cause[tep] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
        reg_wr    = 1'b0;
        drive_fifo();
        chk(int'(resp_valid), int'(e_code != 0), tag, "resp_valid");
        chk(int'(resp_code), e_code, tag, "resp_code");
        if (e_code == 1) chk(int'(resp_data), e_data, tag, "resp_data");
        chk(int'(irq), int'(|(m_flags & m_mask)), tag, "irq");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int e = 0; e < NUM_EP; e++) begin
            fhead[e] = 0;
            fcnt[e]  = 0;
            for (int s = 0; s < DEPTH; s++) fdat[e][s] = '0;
        end
        drive_fifo();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(int'(resp_valid), 0, "R1", "resp_valid");
        chk(int'(resp_code), 0, "R1", "resp_code");
        chk(int'(irq), 0, "R1", "irq");
        for (int a = 0; a < 8; a++) rd(a, "R1");

        // R2, R3, R4: two words then an empty FIFO on endpoint 1
        push(1, 8'hA5);
        push(1, 8'h3C);
        cycle(1, 1, 0, 0, 0, "R2");
        cycle(1, 1, 0, 0, 0, "R2");
        cycle(1, 1, 0, 0, 0, "R3");
        rd(0, "R4");
        rd(5, "R4");
        chk(int'(irq), 1, "R6", "irq after nak");

        // R9: refill and retry
        push(1, 8'h77);
        cycle(1, 1, 0, 0, 0, "R9");

        // R6: masking
        cycle(0, 0, 1, 1, 4'b1101, "R6");
        rd(1, "R10");
        cycle(0, 0, 1, 1, 4'b1111, "R6");

        // R7: write-one-to-clear, write-zero no effect, set beats clear
        cycle(0, 0, 1, 0, 4'b0000, "R7");
        rd(0, "R7");
        cycle(0, 0, 1, 0, 4'b0010, "R7");
        rd(0, "R7");
        cycle(0, 0, 1, 5, 4'b0001, "R7");
        rd(5, "R7");
        cycle(1, 2, 1, 0, 4'b0100, "R7");
        rd(0, "R7");
        cycle(1, 2, 1, 6, 4'b0001, "R7");
        rd(6, "R7");

        // R5: halt forces STALL, no pop, no flag
        push(3, 8'h5E);
        cycle(0, 0, 1, 2, 4'b1001, "R5");
        rd(2, "R10");
        cycle(1, 3, 0, 0, 0, "R5");
        cycle(1, 0, 0, 0, 0, "R5");
        rd(0, "R5");
        rd(4, "R5");
        cycle(0, 0, 1, 2, 4'b0000, "R5");
        cycle(1, 3, 0, 0, 0, "R5");

        // R8: endpoint numbers outside range
        push(0, 8'h11);
        cycle(1, 4, 0, 0, 0, "R8");
        cycle(1, 9, 0, 0, 0, "R8");
        cycle(1, 15, 0, 0, 0, "R8");
        rd(0, "R8");

        // R10: unmapped addresses
        rd(3, "R10");
        rd(8, "R10");
        rd(12, "R10");

        // R11: back-to-back tokens across endpoints
        push(0, 8'h22);
        push(2, 8'hC3);
        cycle(1, 0, 0, 0, 0, "R11");
        cycle(1, 2, 0, 0, 0, "R11");
        cycle(1, 0, 0, 0, 0, "R11");
        cycle(1, 2, 0, 0, 0, "R11");
        cycle(1, 0, 0, 0, 0, "R11");
        cycle(0, 0, 0, 0, 0, "R11");
        for (int a = 0; a < 8; a++) rd(a, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule